// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a small bank of 8-bit configuration registers. It is reached through two byte-wide ports on an I/O bus. A write to the select port latches a register number. The next access to the data port then reads or writes the register that number names. One data access uses up the selection, so software must write the select port again before each data access.

Most of the bank is hidden. One control register is always reachable, and one bit inside it opens the window onto the rest. While that bit is clear, the hidden registers read as all ones and ignore writes. To reach a hidden register, software:

1. selects the control register and reads it,
2. selects it again and writes the value back with the window bit set,
3. makes its access to the hidden register,
4. selects the control register once more and writes back the original value, which closes the window.

One hidden register supplies a high memory base: its two low bits form bits 31:30 of a 32-bit address, and every lower bit is zero.

Top module: `icr_top`

## Requirements
- R1: After reset, the control register and every hidden register hold 0x00, `mem_base` is 0, `io_rdata` is 0x00 and no selection is valid.
- R2: A write to the select port (address 0x22) followed by a read of the data port (address 0x23) returns the selected register on `io_rdata`, one clock after the read strobe.
- R3: The control register (index 0xC3) can always be written and read back through the data port, whatever the state of the window bit.
- R4: While window bit 4 of the control register is 0, a data-port read of a hidden register (indices 0xB8 to 0xBB) returns 0xFF and a data-port write to it leaves it unchanged.
- R5: While window bit 4 is 1, hidden registers are written and read through the data port.
- R6: Each data-port access invalidates the selection. A further data read returns 0xFF and a further data write changes nothing until the select port is written again.
- R7: An index that names neither the control register nor a hidden register reads as 0xFF, and writes to it change no register.
- R8: `mem_base` equals the two low bits of the register at index 0xB8, shifted left by 30. It follows a write one clock after the write strobe.
- R9: Writing the original value back to the control register closes the window. The hidden registers keep their contents and can be read again once the window is reopened.
- R10: Strobes at any address other than 0x22 and 0x23 change no register and leave `io_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current strobe |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data of the last data-port read |
| ctrl_reg | output | 8 | Current control register value |
| cfg_regs | output | 32 | Hidden registers, slot k in bits 8k+7:8k |
| mem_base | output | 32 | Memory base derived from the base register |

## Verification
Every result appears one clock after its strobe. For a read, `io_rdata` carries the value from the rising edge that samples the read strobe. For a write, the register, `ctrl_reg`, `cfg_regs` and `mem_base` all change at the rising edge that samples the write strobe. The bench raises each strobe at a falling edge and drops it at the next falling edge, and it samples the outputs at that second falling edge, half a period after the edge that produced the result. The vector table uses the same cadence, so each expected value is compared at exactly one point, with no cycle of slack in either direction.

// File: rtl/icr_pkg.sv
package icr_pkg;

   typedef enum logic [1:0] {
      ACC_NONE    = 2'd0,
      ACC_SELECT  = 2'd1,
      ACC_DATA_RD = 2'd2,
      ACC_DATA_WR = 2'd3
   } acc_e;

   localparam logic [7:0] NO_DATA = 8'hFF;

   function automatic logic [31:0] base_of(input logic [1:0] sel);
      return {sel, 30'd0};
   endfunction

endpackage

// File: rtl/icr_port_decode.sv
module icr_port_decode
   import icr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int SEL_PORT  = 'h22,
   parameter int DATA_PORT = 'h23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output acc_e              acc,
   output logic [7:0]        sel_q,
   output logic              sel_ok
);

   localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_PORT);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_PORT);

   // a write strobe takes precedence over a read strobe in the same cycle
   always_comb begin
      acc = ACC_NONE;
      if (io_wr && io_addr == SEL_A)
         acc = ACC_SELECT;
      else if (io_wr && io_addr == DATA_A)
         acc = ACC_DATA_WR;
      else if (io_rd && io_addr == DATA_A)
         acc = ACC_DATA_RD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= 8'h00;
         sel_ok <= 1'b0;
      end else begin
         unique case (acc)
            ACC_SELECT: begin
               sel_q  <= io_wdata;
               sel_ok <= 1'b1;
            end
            ACC_DATA_RD,
            ACC_DATA_WR: sel_ok <= 1'b0;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/icr_regfile.sv
module icr_regfile
   import icr_pkg::*;
#(
   parameter int NUM_HID  = 4,
   parameter int HID_BASE = 'hB8,
   parameter int CTRL_IDX = 'hC3,
   parameter int MAP_BIT  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [7:0]           sel,
   input  logic                 sel_ok,
   input  logic [7:0]           wdata,
   output logic [7:0]           ctrl_q,
   output logic [NUM_HID*8-1:0] hid_flat,
   output logic [7:0]           rd_val
);

   localparam logic [7:0] CTRL_I = 8'(CTRL_IDX);

   logic       map_en;
   logic       ctrl_hit;
   logic [7:0] hid_q [NUM_HID];

   assign map_en   = ctrl_q[MAP_BIT];
   assign ctrl_hit = sel_ok && (sel == CTRL_I);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= 8'h00;
      else if (wr_en && ctrl_hit)
         ctrl_q <= wdata;
   end

   for (genvar k = 0; k < NUM_HID; k++) begin : g_slot
      localparam logic [7:0] SLOT_I = 8'(HID_BASE + k);
      logic hit;
      assign hit = sel_ok && map_en && (sel == SLOT_I);

      always_ff @(posedge clk) begin
         if (!rst_n)
            hid_q[k] <= 8'h00;
         else if (wr_en && hit)
            hid_q[k] <= wdata;
      end

      assign hid_flat[k*8 +: 8] = hid_q[k];
   end

   always_comb begin
      rd_val = NO_DATA;
      if (ctrl_hit)
         rd_val = ctrl_q;
      else if (sel_ok && map_en)
         for (int k = 0; k < NUM_HID; k++)
            if (sel == 8'(HID_BASE + k))
               rd_val = hid_q[k];
   end

endmodule

// File: rtl/icr_top.sv
module icr_top
   import icr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int SEL_PORT  = 'h22,
   parameter int DATA_PORT = 'h23,
   parameter int NUM_HID   = 4,
   parameter int HID_BASE  = 'hB8,
   parameter int CTRL_IDX  = 'hC3,
   parameter int MAP_BIT   = 4,
   parameter int BASE_SLOT = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    io_addr,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic [7:0]           io_wdata,
   output logic [7:0]           io_rdata,
   output logic [7:0]           ctrl_reg,
   output logic [NUM_HID*8-1:0] cfg_regs,
   output logic [31:0]          mem_base
);

   if (NUM_HID < 1 || HID_BASE + NUM_HID > 256) begin : g_bad_range
      $error("hidden register range does not fit an 8-bit index");
   end
   if (CTRL_IDX >= HID_BASE && CTRL_IDX < HID_BASE + NUM_HID) begin : g_bad_ctrl
      $error("control index overlaps the hidden range");
   end
   if (MAP_BIT < 0 || MAP_BIT > 7) begin : g_bad_bit
      $error("window bit outside the control byte");
   end
   if (BASE_SLOT < 0 || BASE_SLOT >= NUM_HID) begin : g_bad_base
      $error("base slot outside the hidden range");
   end
   if (SEL_PORT == DATA_PORT || ADDR_W < 8) begin : g_bad_port
      $error("port addresses must differ and fit the address width");
   end

   acc_e       acc;
   logic [7:0] sel_q;
   logic       sel_ok;
   logic [7:0] rd_val;
   logic [7:0] rdata_q;

   icr_port_decode #(
      .ADDR_W   (ADDR_W),
      .SEL_PORT (SEL_PORT),
      .DATA_PORT(DATA_PORT)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .io_rd   (io_rd),
      .io_wdata(io_wdata),
      .acc     (acc),
      .sel_q   (sel_q),
      .sel_ok  (sel_ok)
   );

   icr_regfile #(
      .NUM_HID (NUM_HID),
      .HID_BASE(HID_BASE),
      .CTRL_IDX(CTRL_IDX),
      .MAP_BIT (MAP_BIT)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc == ACC_DATA_WR),
      .sel     (sel_q),
      .sel_ok  (sel_ok),
      .wdata   (io_wdata),
      .ctrl_q  (ctrl_reg),
      .hid_flat(cfg_regs),
      .rd_val  (rd_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= 8'h00;
      else if (acc == ACC_DATA_RD)
         rdata_q <= rd_val;
   end

   assign io_rdata = rdata_q;
   assign mem_base = base_of(cfg_regs[BASE_SLOT*8 +: 2]);

endmodule

// File: rtl/icr_chk.sv
module icr_chk #(
   parameter int ADDR_W    = 16,
   parameter int SEL_PORT  = 'h22,
   parameter int DATA_PORT = 'h23,
   parameter int NUM_HID   = 4,
   parameter int HID_BASE  = 'hB8,
   parameter int CTRL_IDX  = 'hC3,
   parameter int MAP_BIT   = 4,
   parameter int BASE_SLOT = 0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    io_addr,
   input logic                 io_wr,
   input logic                 io_rd,
   input logic [7:0]           io_wdata,
   input logic [7:0]           io_rdata,
   input logic [7:0]           ctrl_reg,
   input logic [NUM_HID*8-1:0] cfg_regs,
   input logic [31:0]          mem_base,
   input logic [7:0]           sel_q,
   input logic                 sel_ok
);

   logic data_wr, data_rd, foreign;
   assign data_wr = io_wr && io_addr == ADDR_W'(DATA_PORT);
   assign data_rd = io_rd && !io_wr && io_addr == ADDR_W'(DATA_PORT);
   assign foreign = io_addr != ADDR_W'(SEL_PORT) && io_addr != ADDR_W'(DATA_PORT);

   a_r6_stale_read: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !sel_ok) |=> io_rdata == 8'hFF);

   a_r3_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && sel_ok && sel_q == 8'(CTRL_IDX)) |=> ctrl_reg == $past(io_wdata));

   a_r4_window_shut: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_reg[MAP_BIT] |=> $stable(cfg_regs));

   a_r10_foreign: assert property (@(posedge clk) disable iff (!rst_n)
      foreign |=> $stable(ctrl_reg) && $stable(cfg_regs) && $stable(sel_ok) && $stable(io_rdata));

   a_r8_base_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && sel_ok && ctrl_reg[MAP_BIT] && sel_q == 8'(HID_BASE + BASE_SLOT))
      |=> mem_base[31:30] == $past(io_wdata[1:0]));

endmodule

bind icr_top icr_chk #(
   .ADDR_W   (ADDR_W),
   .SEL_PORT (SEL_PORT),
   .DATA_PORT(DATA_PORT),
   .NUM_HID  (NUM_HID),
   .HID_BASE (HID_BASE),
   .CTRL_IDX (CTRL_IDX),
   .MAP_BIT  (MAP_BIT),
   .BASE_SLOT(BASE_SLOT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .io_addr (io_addr),
   .io_wr   (io_wr),
   .io_rd   (io_rd),
   .io_wdata(io_wdata),
   .io_rdata(io_rdata),
   .ctrl_reg(ctrl_reg),
   .cfg_regs(cfg_regs),
   .mem_base(mem_base),
   .sel_q   (sel_q),
   .sel_ok  (sel_ok)
);

// File: tb/icr_top_test.sv
module icr_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = 16'h0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h0;
   logic [7:0]  io_rdata;
   logic [7:0]  ctrl_reg;
   logic [31:0] cfg_regs;
   logic [31:0] mem_base;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   icr_top uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .io_rd   (io_rd),
      .io_wdata(io_wdata),
      .io_rdata(io_rdata),
      .ctrl_reg(ctrl_reg),
      .cfg_regs(cfg_regs),
      .mem_base(mem_base)
   );

   // vector fields: req[29:26] op[25:24] (0 write, 1 read and compare) addr[23:16] data[15:8] exp[7:0]
   localparam int NV = 32;
   localparam logic [29:0] VEC [NV] = '{
      {4'd3, 2'd0, 8'h22, 8'hC3, 8'h00},
      {4'd3, 2'd1, 8'h23, 8'h00, 8'h00},
      {4'd3, 2'd0, 8'h22, 8'hC3, 8'h00},
      {4'd3, 2'd0, 8'h23, 8'h10, 8'h00},
      {4'd3, 2'd0, 8'h22, 8'hC3, 8'h00},
      {4'd3, 2'd1, 8'h23, 8'h00, 8'h10},
      {4'd5, 2'd0, 8'h22, 8'hB9, 8'h00},
      {4'd5, 2'd0, 8'h23, 8'h5A, 8'h00},
      {4'd5, 2'd0, 8'h22, 8'hB9, 8'h00},
      {4'd5, 2'd1, 8'h23, 8'h00, 8'h5A},
      {4'd6, 2'd1, 8'h23, 8'h00, 8'hFF},
      {4'd6, 2'd0, 8'h23, 8'h77, 8'h00},
      {4'd6, 2'd0, 8'h22, 8'hB9, 8'h00},
      {4'd6, 2'd1, 8'h23, 8'h00, 8'h5A},
      {4'd7, 2'd0, 8'h22, 8'h40, 8'h00},
      {4'd7, 2'd1, 8'h23, 8'h00, 8'hFF},
      {4'd7, 2'd0, 8'h22, 8'h40, 8'h00},
      {4'd7, 2'd0, 8'h23, 8'h12, 8'h00},
      {4'd9, 2'd0, 8'h22, 8'hC3, 8'h00},
      {4'd9, 2'd0, 8'h23, 8'h00, 8'h00},
      {4'd4, 2'd0, 8'h22, 8'hB9, 8'h00},
      {4'd4, 2'd1, 8'h23, 8'h00, 8'hFF},
      {4'd4, 2'd0, 8'h22, 8'hB9, 8'h00},
      {4'd4, 2'd0, 8'h23, 8'h99, 8'h00},
      {4'd9, 2'd0, 8'h22, 8'hC3, 8'h00},
      {4'd9, 2'd0, 8'h23, 8'h10, 8'h00},
      {4'd9, 2'd0, 8'h22, 8'hB9, 8'h00},
      {4'd9, 2'd1, 8'h23, 8'h00, 8'h5A},
      {4'd2, 2'd0, 8'h22, 8'hBA, 8'h00},
      {4'd2, 2'd1, 8'h23, 8'h00, 8'h00},
      {4'd9, 2'd0, 8'h22, 8'hC3, 8'h00},
      {4'd9, 2'd0, 8'h23, 8'h00, 8'h00}
   };

   function automatic string rname(input int n);
      case (n)
         1: return "R1";   2: return "R2";   3: return "R3";
         4: return "R4";   5: return "R5";   6: return "R6";
         7: return "R7";   8: return "R8";   9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [15:0] a);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      check("R1", {24'd0, io_rdata}, 32'h0);
      check("R1", {24'd0, ctrl_reg}, 32'h0);
      check("R1", cfg_regs, 32'h0);
      check("R1", mem_base, 32'h0);
      rst_n = 1'b1;
      // R1: no selection is valid after reset
      bus_rd(16'h23);
      check("R1", {24'd0, io_rdata}, 32'hFF);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][25:24] == 2'd0)
            bus_wr({8'h00, VEC[i][23:16]}, VEC[i][15:8]);
         else begin
            bus_rd({8'h00, VEC[i][23:16]});
            check(rname(int'(VEC[i][29:26])), {24'd0, io_rdata}, {24'd0, VEC[i][7:0]});
         end
      end
      // R7: the write to index 0x40 touched nothing
      check("R7", cfg_regs, 32'h0000_5A00);

      // R8: base register and derived address
      bus_wr(16'h22, 8'hC3); bus_wr(16'h23, 8'h10);
      bus_wr(16'h22, 8'hB8); bus_wr(16'h23, 8'h03);
      check("R8", mem_base, 32'hC000_0000);
      bus_wr(16'h22, 8'hB8); bus_wr(16'h23, 8'hFE);
      check("R8", mem_base, 32'h8000_0000);
      check("R5", cfg_regs, 32'h0000_5AFE);

      // R10: foreign addresses change nothing
      bus_wr(16'h22, 8'hB8); bus_rd(16'h23);
      check("R2", {24'd0, io_rdata}, 32'hFE);
      bus_wr(16'h24, 8'h00);
      bus_wr(16'h0123, 8'h55);
      bus_rd(16'h21);
      check("R10", {24'd0, io_rdata}, 32'hFE);
      check("R10", {24'd0, ctrl_reg}, 32'h10);
      check("R10", cfg_regs, 32'h0000_5AFE);
      bus_wr(16'h22, 8'hC3); bus_wr(16'h0223, 8'h00);
      bus_rd(16'h23);
      check("R10", {24'd0, io_rdata}, 32'h10);

      // R1: reset mid-run clears everything
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R1", {24'd0, ctrl_reg}, 32'h0);
      check("R1", cfg_regs, 32'h0);
      check("R1", mem_base, 32'h0);
      check("R1", {24'd0, io_rdata}, 32'h0);
      rst_n = 1'b1;
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule